// File: doc/BRIEF.md
# Clock Frequency Source Selector

This block chooses the frequency setting that a clock synthesizer runs from. At power-up it captures a five-bit frequency strap code and a mode strap. Capture is qualified by an active-low power-good strobe. Once the first low sample has been taken, the captured values never change again. Software registers then choose the active setting from one of three sources: the latched strap code, a software select field, or a programmed N/M divider pair. The programmed frequency is G*(N+3)/(M+3), where G is the gear constant picked by the five-bit code.

The outputs are the selected five-bit ratio code, the active N and M values, a flag that marks when the divider pair is in use, and a one-cycle change strobe. A recovery lock input, driven by a watchdog, overrides the normal choice. While it is held, the block presents a recovery setting and ignores every register write. The latched mode strap is also brought out. It tells the pad logic whether two shared pins carry the memory-reference clock pair or serve as CPU and PCI stop inputs.

Top module: `freq_src_sel`

## Requirements
- R1: Out of reset `straps_valid` is 0. On the first rising clock edge where `pwrgd_n` is 0, `strap_fs` is captured into `latched_fs` and `strap_mode` into `mref_mode`, and `straps_valid` becomes 1.
- R2: Once `straps_valid` is 1, `latched_fs` and `mref_mode` keep their values whatever `pwrgd_n` and the straps do, until the next reset.
- R3: `mref_mode` = 1 means the shared pins are memory-reference clock outputs. `mref_mode` = 0 means they are stop inputs.
- R4: The register map (byte offset to contents) is: 0 control, 1 select field in bits 4:0, 2 N, 3 M in bits 6:0, 4 recovery N, 5 recovery M in bits 6:0. Control bit 0 is override, bit 1 is programmable enable and bit 2 is recovery select. With programmable enable 0 and no lock, `ratio_code` is `latched_fs` when override is 0 and the select field when override is 1. `prog_active` is then 0 and `n_val` and `m_val` are 0.
- R5: With programmable enable 1 and no lock, `prog_active` is 1 and `n_val`/`m_val` show the active programmed pair. `ratio_code` still follows the override choice. The pair resets to N=97, M=93.
- R6: A write to N or M forms a pair from the new byte and the last written value of the other register. The pair becomes active only if N > M, which is the condition for (N+3)/(M+3) > 1. If N ≤ M, `invalid` goes to 1 and the previous active pair is kept. A later accepted pair clears `invalid`.
- R7: An accepted write to offset 2 or 3 pulses `freq_chg` high for exactly the cycle after the write, whether or not the pair is valid.
- R8: `freq_chg` also pulses when a write changes the override bit, the programmable-enable bit or the select field. Rewriting the same value gives no pulse.
- R9: With `rcv_lock` = 1 and recovery select 1, `n_val`/`m_val` show the recovery registers and `prog_active` is 1. `ratio_code` follows the override choice.
- R10: With `rcv_lock` = 1 and recovery select 0, `ratio_code` is `latched_fs`, `prog_active` is 0 and `n_val`/`m_val` are 0.
- R11: While `rcv_lock` = 1, every register write is ignored. No state changes and no strobe is produced.
- R12: Every change of `rcv_lock` pulses `freq_chg` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwrgd_n | input | 1 | Power-good strobe, active low, qualifies strap capture |
| strap_fs | input | 5 | Frequency strap code |
| strap_mode | input | 1 | Mode strap |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register byte offset |
| wr_data | input | 8 | Register write data |
| rcv_lock | input | 1 | Watchdog recovery lock |
| ratio_code | output | 5 | Selected ratio / gear code |
| n_val | output | 8 | Active N value (0 when unused) |
| m_val | output | 7 | Active M value (0 when unused) |
| prog_active | output | 1 | Divider pair in use |
| freq_chg | output | 1 | One-cycle frequency change strobe |
| invalid | output | 1 | Last programmed pair broke the ratio rule |
| straps_valid | output | 1 | Straps captured |
| latched_fs | output | 5 | Captured strap code |
| mref_mode | output | 1 | Captured mode strap |

## Verification
Every one of the 32 strap codes is captured after its own reset, with the mode strap alternating. A second capture attempt with the inverted code then shows whether the latch freezes or keeps sampling. All 32 select-field values are swept with override set, and the strobe is predicted from whether each value differs from the previous one. This separates pulses caused by a real change from pulses caused by any write. Divider pairs are tried at N = M-1, M and M+1 for several M, including the M extremes. This places the ratio rule exactly at its boundary and shows whether a rejected pair disturbs the active one. The recovery sequence writes N under lock and then releases the lock. Comparing the outputs afterwards shows whether the locked write leaked into state.

// File: rtl/fss_pkg.sv
package fss_pkg;
   localparam int unsigned OFF_CTRL = 0;
   localparam int unsigned OFF_SEL  = 1;
   localparam int unsigned OFF_N    = 2;
   localparam int unsigned OFF_M    = 3;
   localparam int unsigned OFF_RN   = 4;
   localparam int unsigned OFF_RM   = 5;

   localparam int unsigned CB_OVR  = 0;
   localparam int unsigned CB_PROG = 1;
   localparam int unsigned CB_RSEL = 2;

   typedef struct packed {
      logic rsel;
      logic prog;
      logic ovr;
   } ctrl_t;
endpackage

// File: rtl/fss_strap_latch.sv
module fss_strap_latch #(
   parameter int unsigned CODE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwrgd_n,
   input  logic [CODE_W-1:0] strap_fs,
   input  logic              strap_mode,
   output logic [CODE_W-1:0] fs_q,
   output logic              mode_q,
   output logic              valid_q
);
   logic take;
   assign take = !valid_q && !pwrgd_n;

   for (genvar i = 0; i < CODE_W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    fs_q[i] <= 1'b0;
         else if (take) fs_q[i] <= strap_fs[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= 1'b0;
         valid_q <= 1'b0;
      end else if (take) begin
         mode_q  <= strap_mode;
         valid_q <= 1'b1;
      end
   end
endmodule

// File: rtl/fss_regs.sv
module fss_regs
   import fss_pkg::*;
#(
   parameter int unsigned CODE_W = 5,
   parameter int unsigned N_W    = 8,
   parameter int unsigned M_W    = 7,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEF_N  = 97,
   parameter int unsigned DEF_M  = 93
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              lock,
   output ctrl_t             ctrl_q,
   output logic [CODE_W-1:0] sel_q,
   output logic [N_W-1:0]    act_n,
   output logic [M_W-1:0]    act_m,
   output logic [N_W-1:0]    rn_q,
   output logic [M_W-1:0]    rm_q,
   output logic              invalid_q,
   output logic              chg_q
);
   localparam int unsigned CMP_W = (N_W > M_W) ? N_W : M_W;

   logic              acc;
   logic              hit_ctrl, hit_sel, hit_n, hit_m, hit_rn, hit_rm;
   logic [N_W-1:0]    raw_n;
   logic [M_W-1:0]    raw_m;
   logic [N_W-1:0]    cand_n;
   logic [M_W-1:0]    cand_m;
   logic              cand_ok;
   logic              lock_q;
   logic              ctrl_diff, sel_diff, chg_d;

   assign acc      = wr_en && !lock;
   assign hit_ctrl = acc && (wr_addr == ADDR_W'(OFF_CTRL));
   assign hit_sel  = acc && (wr_addr == ADDR_W'(OFF_SEL));
   assign hit_n    = acc && (wr_addr == ADDR_W'(OFF_N));
   assign hit_m    = acc && (wr_addr == ADDR_W'(OFF_M));
   assign hit_rn   = acc && (wr_addr == ADDR_W'(OFF_RN));
   assign hit_rm   = acc && (wr_addr == ADDR_W'(OFF_RM));

   assign cand_n  = hit_n ? wr_data[N_W-1:0] : raw_n;
   assign cand_m  = hit_m ? wr_data[M_W-1:0] : raw_m;
   assign cand_ok = CMP_W'(cand_n) > CMP_W'(cand_m);

   assign ctrl_diff = (wr_data[CB_OVR] != ctrl_q.ovr) || (wr_data[CB_PROG] != ctrl_q.prog);
   assign sel_diff  = wr_data[CODE_W-1:0] != sel_q;
   assign chg_d     = hit_n || hit_m || (hit_ctrl && ctrl_diff) ||
                      (hit_sel && sel_diff) || (lock != lock_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         sel_q     <= '0;
         raw_n     <= N_W'(DEF_N);
         raw_m     <= M_W'(DEF_M);
         act_n     <= N_W'(DEF_N);
         act_m     <= M_W'(DEF_M);
         rn_q      <= '0;
         rm_q      <= '0;
         invalid_q <= 1'b0;
         lock_q    <= 1'b0;
         chg_q     <= 1'b0;
      end else begin
         lock_q <= lock;
         chg_q  <= chg_d;
         if (hit_ctrl) begin
            ctrl_q.ovr  <= wr_data[CB_OVR];
            ctrl_q.prog <= wr_data[CB_PROG];
            ctrl_q.rsel <= wr_data[CB_RSEL];
         end
         if (hit_sel) sel_q <= wr_data[CODE_W-1:0];
         if (hit_rn)  rn_q  <= wr_data[N_W-1:0];
         if (hit_rm)  rm_q  <= wr_data[M_W-1:0];
         if (hit_n || hit_m) begin
            raw_n <= cand_n;
            raw_m <= cand_m;
            if (cand_ok) begin
               act_n     <= cand_n;
               act_m     <= cand_m;
               invalid_q <= 1'b0;
            end else begin
               invalid_q <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/fss_mux.sv
module fss_mux
   import fss_pkg::*;
#(
   parameter int unsigned CODE_W = 5,
   parameter int unsigned N_W    = 8,
   parameter int unsigned M_W    = 7
) (
   input  ctrl_t             ctrl,
   input  logic              lock,
   input  logic [CODE_W-1:0] fs_q,
   input  logic [CODE_W-1:0] sel_q,
   input  logic [N_W-1:0]    act_n,
   input  logic [M_W-1:0]    act_m,
   input  logic [N_W-1:0]    rn_q,
   input  logic [M_W-1:0]    rm_q,
   output logic [CODE_W-1:0] code,
   output logic [N_W-1:0]    n_o,
   output logic [M_W-1:0]    m_o,
   output logic              prog_o
);
   logic [CODE_W-1:0] ovr_code;
   assign ovr_code = ctrl.ovr ? sel_q : fs_q;

   always_comb begin
      code   = ovr_code;
      n_o    = '0;
      m_o    = '0;
      prog_o = 1'b0;
      if (lock) begin
         if (ctrl.rsel) begin
            prog_o = 1'b1;
            n_o    = rn_q;
            m_o    = rm_q;
         end else begin
            code = fs_q;
         end
      end else if (ctrl.prog) begin
         prog_o = 1'b1;
         n_o    = act_n;
         m_o    = act_m;
      end
   end
endmodule

// File: rtl/freq_src_sel.sv
module freq_src_sel
   import fss_pkg::*;
#(
   parameter int unsigned CODE_W = 5,
   parameter int unsigned N_W    = 8,
   parameter int unsigned M_W    = 7,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEF_N  = 97,
   parameter int unsigned DEF_M  = 93
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwrgd_n,
   input  logic [CODE_W-1:0] strap_fs,
   input  logic              strap_mode,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rcv_lock,
   output logic [CODE_W-1:0] ratio_code,
   output logic [N_W-1:0]    n_val,
   output logic [M_W-1:0]    m_val,
   output logic              prog_active,
   output logic              freq_chg,
   output logic              invalid,
   output logic              straps_valid,
   output logic [CODE_W-1:0] latched_fs,
   output logic              mref_mode
);
   if (CODE_W > DATA_W || N_W > DATA_W || M_W > DATA_W) begin : g_bad_w
      $error("field wider than write data");
   end
   if ((1 << ADDR_W) <= OFF_RM) begin : g_bad_a
      $error("address too narrow for register map");
   end
   if (DEF_N <= DEF_M || DEF_N >= (1 << N_W) || DEF_M >= (1 << M_W)) begin : g_bad_def
      $error("default divider pair out of range or breaks ratio rule");
   end

   ctrl_t             ctrl_q;
   logic [CODE_W-1:0] sel_q;
   logic [N_W-1:0]    act_n, rn_q;
   logic [M_W-1:0]    act_m, rm_q;

   fss_strap_latch #(.CODE_W(CODE_W)) u_latch (
      .clk(clk), .rst_n(rst_n), .pwrgd_n(pwrgd_n),
      .strap_fs(strap_fs), .strap_mode(strap_mode),
      .fs_q(latched_fs), .mode_q(mref_mode), .valid_q(straps_valid)
   );

   fss_regs #(
      .CODE_W(CODE_W), .N_W(N_W), .M_W(M_W), .ADDR_W(ADDR_W),
      .DATA_W(DATA_W), .DEF_N(DEF_N), .DEF_M(DEF_M)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .lock(rcv_lock), .ctrl_q(ctrl_q), .sel_q(sel_q),
      .act_n(act_n), .act_m(act_m), .rn_q(rn_q), .rm_q(rm_q),
      .invalid_q(invalid), .chg_q(freq_chg)
   );

   fss_mux #(.CODE_W(CODE_W), .N_W(N_W), .M_W(M_W)) u_mux (
      .ctrl(ctrl_q), .lock(rcv_lock), .fs_q(latched_fs), .sel_q(sel_q),
      .act_n(act_n), .act_m(act_m), .rn_q(rn_q), .rm_q(rm_q),
      .code(ratio_code), .n_o(n_val), .m_o(m_val), .prog_o(prog_active)
   );
endmodule

// File: rtl/fss_chk.sv
module fss_chk
   import fss_pkg::*;
#(
   parameter int unsigned CODE_W = 5,
   parameter int unsigned N_W    = 8,
   parameter int unsigned M_W    = 7,
   parameter int unsigned ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              rcv_lock,
   input logic [CODE_W-1:0] ratio_code,
   input logic [N_W-1:0]    n_val,
   input logic [M_W-1:0]    m_val,
   input logic              prog_active,
   input logic              freq_chg,
   input logic              invalid,
   input logic              straps_valid,
   input logic [CODE_W-1:0] latched_fs,
   input logic              mref_mode
);
   localparam int unsigned CW = (N_W > M_W) ? N_W : M_W;

   p_strap_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      straps_valid |=> ($stable(latched_fs) && $stable(mref_mode) && straps_valid));

   p_chg_on_div_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !rcv_lock && (wr_addr == ADDR_W'(OFF_N) || wr_addr == ADDR_W'(OFF_M)))
      |=> freq_chg);

   p_ratio_rule_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_active && !rcv_lock) |-> (CW'(n_val) > CW'(m_val)));

   p_reject_keeps_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(invalid) && !rcv_lock && $past(!rcv_lock)) |-> ($stable(n_val) && $stable(m_val)));

   p_lock_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rcv_lock && $past(rcv_lock) && straps_valid && $past(straps_valid))
      |-> ($stable(n_val) && $stable(m_val) && $stable(ratio_code) && $stable(prog_active)));

   p_lock_edge_chg_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rcv_lock) |=> freq_chg);
endmodule

bind freq_src_sel fss_chk #(
   .CODE_W(CODE_W), .N_W(N_W), .M_W(M_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .rcv_lock(rcv_lock), .ratio_code(ratio_code), .n_val(n_val),
   .m_val(m_val), .prog_active(prog_active), .freq_chg(freq_chg),
   .invalid(invalid), .straps_valid(straps_valid),
   .latched_fs(latched_fs), .mref_mode(mref_mode)
);

// File: tb/sim_freq_src_sel.sv
module sim_freq_src_sel;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwrgd_n = 1'b1;
   logic [4:0] strap_fs = '0;
   logic       strap_mode = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       rcv_lock = 1'b0;
   logic [4:0] ratio_code, latched_fs;
   logic [7:0] n_val;
   logic [6:0] m_val;
   logic       prog_active, freq_chg, invalid, straps_valid, mref_mode;

   int nchk = 0;
   int nfail = 0;

   always #5 clk = ~clk;

   freq_src_sel u0 (
      .clk(clk), .rst_n(rst_n), .pwrgd_n(pwrgd_n), .strap_fs(strap_fs),
      .strap_mode(strap_mode), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rcv_lock(rcv_lock), .ratio_code(ratio_code),
      .n_val(n_val), .m_val(m_val), .prog_active(prog_active),
      .freq_chg(freq_chg), .invalid(invalid), .straps_valid(straps_valid),
      .latched_fs(latched_fs), .mref_mode(mref_mode)
   );

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; pwrgd_n = 1'b1; wr_en = 1'b0; rcv_lock = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic latch_straps(input logic [4:0] c, input logic md);
      strap_fs = c; strap_mode = md; pwrgd_n = 1'b0;
      @(negedge clk);
      pwrgd_n = 1'b1;
   endtask

   // write at next edge; returns right after the following negedge
   task automatic wr(input int a, input int d);
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL WDOG actual=%0d expected=%0d", 1, 0);
      finish_up();
   end

   initial begin
      logic [4:0] prev_sel;
      int exp_n, exp_m, raw_n, raw_m, exp_inv;
      int mlist[5];
      mlist = '{0, 1, 45, 93, 127};

      do_reset();
      // reset state
      chk("R1 reset valid", straps_valid, 0);
      chk("R4 reset code", ratio_code, 0);
      chk("R4 reset n", n_val, 0);
      chk("R4 reset prog", prog_active, 0);
      chk("R6 reset invalid", invalid, 0);
      chk("R7 reset chg", freq_chg, 0);

      // every strap code, second capture attempt must be ignored
      for (int c = 0; c < 32; c++) begin
         do_reset();
         strap_fs = 5'(c); pwrgd_n = 1'b1;
         @(negedge clk);
         chk("R1 no capture while pwrgd high", straps_valid, 0);
         latch_straps(5'(c), c[0]);
         chk("R1 valid", straps_valid, 1);
         chk("R1 captured code", latched_fs, c);
         chk("R4 code from straps", ratio_code, c);
         chk("R3 mode", mref_mode, c[0]);
         latch_straps(~5'(c), ~c[0]);
         @(negedge clk);
         chk("R2 frozen code", latched_fs, c);
         chk("R2 frozen mode", mref_mode, c[0]);
      end

      do_reset();
      latch_straps(5'b01010, 1'b1);

      // override with select field sweep
      wr(0, 8'h01);
      chk("R8 override change pulse", freq_chg, 1);
      @(negedge clk);
      chk("R7 pulse single", freq_chg, 0);
      wr(0, 8'h01);
      chk("R8 same ctrl no pulse", freq_chg, 0);
      prev_sel = 5'd0;
      for (int s = 0; s < 32; s++) begin
         wr(1, s);
         chk("R4 select field", ratio_code, s);
         chk("R8 sel pulse", freq_chg, (5'(s) != prev_sel) ? 1 : 0);
         prev_sel = 5'(s);
      end
      wr(1, 31);
      chk("R8 same sel no pulse", freq_chg, 0);
      wr(0, 8'h00);
      chk("R4 back to straps", ratio_code, 5'b01010);
      chk("R4 prog off n", n_val, 0);

      // programmable mode, defaults
      wr(0, 8'h02);
      chk("R8 prog enable pulse", freq_chg, 1);
      chk("R5 prog active", prog_active, 1);
      chk("R5 default n", n_val, 97);
      chk("R5 default m", m_val, 93);
      chk("R5 code follows straps", ratio_code, 5'b01010);

      // ratio rule boundary sweep
      exp_n = 97; exp_m = 93; raw_n = 97; raw_m = 93; exp_inv = 0;
      foreach (mlist[k]) begin
         for (int d = -1; d <= 1; d++) begin
            int nn;
            nn = mlist[k] + d;
            if (nn < 0) continue;
            wr(2, 255); raw_n = 255;
            if (raw_n > raw_m) begin exp_n = raw_n; exp_m = raw_m; exp_inv = 0; end
            else exp_inv = 1;
            wr(3, mlist[k]); raw_m = mlist[k];
            if (raw_n > raw_m) begin exp_n = raw_n; exp_m = raw_m; exp_inv = 0; end
            else exp_inv = 1;
            wr(2, nn); raw_n = nn;
            if (raw_n > raw_m) begin exp_n = raw_n; exp_m = raw_m; exp_inv = 0; end
            else exp_inv = 1;
            chk("R7 n write pulse", freq_chg, 1);
            chk("R6 invalid flag", invalid, exp_inv);
            chk("R6 active n", n_val, exp_n);
            chk("R6 active m", m_val, exp_m);
         end
      end
      // M write that breaks the rule
      wr(2, 50); raw_n = 50;
      if (raw_n > raw_m) begin exp_n = raw_n; exp_m = raw_m; exp_inv = 0; end
      else exp_inv = 1;
      wr(3, 60); raw_m = 60;
      if (raw_n > raw_m) begin exp_n = raw_n; exp_m = raw_m; exp_inv = 0; end
      else exp_inv = 1;
      chk("R7 m write pulse", freq_chg, 1);
      chk("R6 m write invalid", invalid, exp_inv);
      chk("R6 m write kept n", n_val, exp_n);
      chk("R6 m write kept m", m_val, exp_m);
      wr(3, 10); raw_m = 10;
      exp_n = 50; exp_m = 10; exp_inv = 0;
      chk("R6 invalid cleared", invalid, 0);
      chk("R6 new pair n", n_val, exp_n);

      wr(0, 8'h03);
      chk("R5 code from select", ratio_code, 31);

      // recovery from recovery registers
      wr(4, 200);
      wr(5, 45);
      wr(0, 8'h07);
      chk("R8 rsel only no pulse", freq_chg, 0);
      rcv_lock = 1'b1;
      @(negedge clk);
      chk("R12 lock rise pulse", freq_chg, 1);
      chk("R9 rec n", n_val, 200);
      chk("R9 rec m", m_val, 45);
      chk("R9 rec prog", prog_active, 1);
      chk("R9 rec code", ratio_code, 31);
      wr(2, 150);
      chk("R11 locked write no pulse", freq_chg, 0);
      chk("R11 locked write n", n_val, 200);
      wr(0, 8'h00);
      chk("R11 locked ctrl write", ratio_code, 31);
      rcv_lock = 1'b0;
      @(negedge clk);
      chk("R12 lock fall pulse", freq_chg, 1);
      chk("R11 n unchanged after lock", n_val, exp_n);
      chk("R11 ctrl unchanged after lock", prog_active, 1);

      // recovery from straps
      wr(0, 8'h03);
      rcv_lock = 1'b1;
      @(negedge clk);
      chk("R10 rec code straps", ratio_code, 5'b01010);
      chk("R10 rec prog off", prog_active, 0);
      chk("R10 rec n zero", n_val, 0);
      rcv_lock = 1'b0;
      @(negedge clk);
      @(negedge clk);
      finish_up();
   end
endmodule